// File: doc/BRIEF.md
# Packet Queue Interrupt Controller

This block keeps the packet-number queues that connect a host driver to a network MAC, and it raises interrupts straight from how full those queues are. There are three queues. The transmit queue holds packets the host has handed over for sending. The completion queue holds packets whose transmission has finished and which the host must still look at. The receive queue holds packets that have arrived. Each entry is a small packet number. The packet contents, and the transmit or receive result for each packet, stay in packet memory outside this block. Because of that, the host never has to read a register before the next packet can be handled.

When the MAC finishes a transmit it reports a pass/fail status, and the packet at the head of the transmit queue is retired. In auto-release mode a packet that was sent successfully skips the completion queue. Instead its number goes to the page allocator as a one-cycle release request. Two interrupt styles follow from this. With auto-release off, the host takes one completion interrupt per packet. With auto-release on, the host takes the transmit-empty interrupt once per burst.

Top module: `pkt_irq_ctrl`

## Requirements
- R1: Status bit 0 (receive) is 1 exactly when the receive queue holds at least one packet. It reflects a push or pop from the clock edge on which that push or pop is taken.
- R2: Status bit 1 (transmit complete) is 1 exactly when the completion queue holds at least one packet.
- R3: Status bit 2 (transmit empty) is 1 exactly when the transmit queue holds no packet.
- R4: `irq` is the OR, over all four status bits, of each status bit ANDed with the `intEn` bit at the same position. It is combinational, with no register delay.
- R5: A transmit-done event while the transmit queue is non-empty removes the head packet from the transmit queue. If auto-release is off, or if the status reports failure, that packet number is appended to the completion queue.
- R6: A transmit-done event with `txOk`=1 and `autoRelease`=1 does not write the completion queue. In the same cycle as the event it drives `relValid` high for one cycle, with `relPkt` equal to the retired packet number.
- R7: Each queue is first-in first-out and holds up to 8 packet numbers of 5 bits. The oldest entry of each queue is shown on its head output.
- R8: A push into a full queue is dropped and leaves the queue unchanged. It sets the sticky overflow flag, which is status bit 3. That flag clears only on a cycle with `ovfClr`=1 and no new overflow.
- R9: A dequeue from an empty queue, or a transmit-done event while the transmit queue is empty, has no effect: no queue changes and no release request is issued.
- R10: After reset every queue is empty, the overflow flag is clear, and the status reads 4'b0100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostTxEnq | input | 1 | Host pushes a packet into the transmit queue |
| hostTxPkt | input | 5 | Packet number to push into the transmit queue |
| txDone | input | 1 | MAC has finished transmitting the head packet |
| txOk | input | 1 | Transmit status with txDone: 1 = success |
| txHeadPkt | output | 5 | Packet at the head of the transmit queue |
| rxArrive | input | 1 | A received packet is pushed into the receive queue |
| rxPkt | input | 5 | Packet number of the received packet |
| hostRxDeq | input | 1 | Host removes the head of the receive queue |
| rxHeadPkt | output | 5 | Packet at the head of the receive queue |
| hostDoneDeq | input | 1 | Host removes the head of the completion queue |
| doneHeadPkt | output | 5 | Packet at the head of the completion queue |
| autoRelease | input | 1 | Auto-release mode for successful transmits |
| intEn | input | 4 | Interrupt enable, one bit per status bit |
| ovfClr | input | 1 | Clears the sticky overflow flag |
| intStatus | output | 4 | {overflow, txEmpty, txComplete, rx} |
| irq | output | 1 | Interrupt line |
| relValid | output | 1 | Page release request (one-cycle pulse) |
| relPkt | output | 5 | Packet number to release |

## Verification
The release request is combinational from the transmit-done event. The bench therefore samples `relValid` and `relPkt` one nanosecond after driving the inputs, inside the same cycle and before the clock edge. Queue occupancy and the overflow flag are registered. The status bits, the head outputs and `irq` are therefore sampled one nanosecond after the rising edge that takes the strobe, which is the first point at which they are due. Inputs are driven on falling edges, so every strobe is stable across exactly one rising edge.

// File: rtl/pkt_irq_pkg.sv
package pkt_irq_pkg;
  localparam int PKT_W   = 5;
  localparam int Q_DEPTH = 8;
  localparam int NUM_Q   = 3;
  localparam int ST_W    = 4;
  // queue indices
  localparam int Q_TX   = 0;
  localparam int Q_DONE = 1;
  localparam int Q_RX   = 2;

  typedef struct packed {
    logic [NUM_Q-1:0] push;
    logic [NUM_Q-1:0] pop;
  } qStrb_t;
endpackage

// File: rtl/pkt_irq_fifo.sv
module pkt_irq_fifo #(
  parameter int WIDTH = 5,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             wrEn, rdEn;

  assign empty = (count == '0);
  assign full  = (count == CNT_W'(DEPTH));
  assign wrEn  = push && !full;
  assign rdEn  = pop && !empty;
  assign head  = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (wrEn) wrPtr <= nextPtr(wrPtr);
      if (rdEn) rdPtr <= nextPtr(rdPtr);
      case ({wrEn, rdEn})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrPtr] <= din;
  end

  p_count_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop) |=> full);
  p_empty_pop_r9: assert property (@(posedge clk) disable iff (!rstN)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/pkt_irq_datapath.sv
module pkt_irq_datapath
  import pkt_irq_pkg::*;
#(
  parameter int WIDTH = PKT_W,
  parameter int DEPTH = Q_DEPTH
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  qStrb_t                      strb,
  input  logic [WIDTH-1:0]            hostTxPkt,
  input  logic [WIDTH-1:0]            rxPkt,
  output logic [NUM_Q-1:0][WIDTH-1:0] qHead,
  output logic [NUM_Q-1:0]            qEmpty,
  output logic [NUM_Q-1:0]            qFull
);
  logic [NUM_Q-1:0][WIDTH-1:0] qDin;

  // the completion queue is filled from the transmit queue head
  always_comb begin
    qDin         = '0;
    qDin[Q_TX]   = hostTxPkt;
    qDin[Q_DONE] = qHead[Q_TX];
    qDin[Q_RX]   = rxPkt;
  end

  for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
    pkt_irq_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo (
      .clk   (clk),
      .rstN  (rstN),
      .push  (strb.push[q]),
      .pop   (strb.pop[q]),
      .din   (qDin[q]),
      .head  (qHead[q]),
      .empty (qEmpty[q]),
      .full  (qFull[q])
    );
  end
endmodule

// File: rtl/pkt_irq_control.sv
module pkt_irq_control
  import pkt_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostTxEnq,
  input  logic             txDone,
  input  logic             txOk,
  input  logic             rxArrive,
  input  logic             hostRxDeq,
  input  logic             hostDoneDeq,
  input  logic             autoRelease,
  input  logic [ST_W-1:0]  intEn,
  input  logic             ovfClr,
  input  logic [NUM_Q-1:0] qEmpty,
  input  logic [NUM_Q-1:0] qFull,
  output qStrb_t           strb,
  output logic [ST_W-1:0]  intStatus,
  output logic             irq,
  output logic             relValid
);
  logic txRetire, autoFree, ovfHit, ovfFlag;

  assign txRetire = txDone && !qEmpty[Q_TX];
  assign autoFree = autoRelease && txOk;
  assign relValid = txRetire && autoFree;

  always_comb begin
    strb              = '0;
    strb.push[Q_TX]   = hostTxEnq;
    strb.pop[Q_TX]    = txRetire;
    strb.push[Q_DONE] = txRetire && !autoFree;
    strb.pop[Q_DONE]  = hostDoneDeq;
    strb.push[Q_RX]   = rxArrive;
    strb.pop[Q_RX]    = hostRxDeq;
  end

  assign ovfHit = |(strb.push & qFull);

  always_ff @(posedge clk) begin
    if (!rstN)       ovfFlag <= 1'b0;
    else if (ovfHit) ovfFlag <= 1'b1;
    else if (ovfClr) ovfFlag <= 1'b0;
  end

  assign intStatus = {ovfFlag, qEmpty[Q_TX], !qEmpty[Q_DONE], !qEmpty[Q_RX]};
  assign irq       = |(intStatus & intEn);

  p_done_push_r5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push[Q_DONE] && !qFull[Q_DONE]) |=> !qEmpty[Q_DONE]);
  p_rel_excl_r6: assert property (@(posedge clk) disable iff (!rstN)
    relValid |-> !strb.push[Q_DONE]);
  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !ovfClr) |=> ovfFlag);
  p_rx_status_r1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push[Q_RX] && !strb.pop[Q_RX]) |=> intStatus[0]);
endmodule

// File: rtl/pkt_irq_ctrl.sv
module pkt_irq_ctrl
  import pkt_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             hostTxEnq,
  input  logic [PKT_W-1:0] hostTxPkt,
  input  logic             txDone,
  input  logic             txOk,
  output logic [PKT_W-1:0] txHeadPkt,
  input  logic             rxArrive,
  input  logic [PKT_W-1:0] rxPkt,
  input  logic             hostRxDeq,
  output logic [PKT_W-1:0] rxHeadPkt,
  input  logic             hostDoneDeq,
  output logic [PKT_W-1:0] doneHeadPkt,
  input  logic             autoRelease,
  input  logic [ST_W-1:0]  intEn,
  input  logic             ovfClr,
  output logic [ST_W-1:0]  intStatus,
  output logic             irq,
  output logic             relValid,
  output logic [PKT_W-1:0] relPkt
);
  qStrb_t                      strb;
  logic [NUM_Q-1:0][PKT_W-1:0] qHead;
  logic [NUM_Q-1:0]            qEmpty, qFull;

  pkt_irq_control u_ctrl (
    .clk, .rstN, .hostTxEnq, .txDone, .txOk, .rxArrive, .hostRxDeq,
    .hostDoneDeq, .autoRelease, .intEn, .ovfClr,
    .qEmpty (qEmpty),
    .qFull  (qFull),
    .strb   (strb),
    .intStatus, .irq, .relValid
  );

  pkt_irq_datapath #(.WIDTH(PKT_W), .DEPTH(Q_DEPTH)) u_dp (
    .clk, .rstN,
    .strb      (strb),
    .hostTxPkt (hostTxPkt),
    .rxPkt     (rxPkt),
    .qHead     (qHead),
    .qEmpty    (qEmpty),
    .qFull     (qFull)
  );

  assign txHeadPkt   = qHead[Q_TX];
  assign doneHeadPkt = qHead[Q_DONE];
  assign rxHeadPkt   = qHead[Q_RX];
  assign relPkt      = qHead[Q_TX];
endmodule

// File: tb/sim_pkt_irq_ctrl.sv
`timescale 1ns/1ps
module sim_pkt_irq_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostTxEnq = 0, txDone = 0, txOk = 0, rxArrive = 0;
  logic hostRxDeq = 0, hostDoneDeq = 0, autoRelease = 0, ovfClr = 0;
  logic [4:0] hostTxPkt = 0, rxPkt = 0;
  logic [3:0] intEn = 0;
  logic [4:0] txHeadPkt, rxHeadPkt, doneHeadPkt, relPkt;
  logic [3:0] intStatus;
  logic irq, relValid;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  pkt_irq_ctrl u0 (.*);

  typedef struct packed {
    logic       txEnq; logic [4:0] txPkt; logic done; logic ok; logic autoR;
    logic       rxArr; logic [4:0] rxP; logic rxDeq; logic doneDeq;
    logic [3:0] expStat; logic expRel; logic [4:0] expRelPkt;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{1'b1,5'd3, 1'b0,1'b0,1'b0, 1'b0,5'd0, 1'b0,1'b0, 4'b0000,1'b0,5'd0}, // R3 tx queue filled
    '{1'b1,5'd7, 1'b0,1'b0,1'b0, 1'b0,5'd0, 1'b0,1'b0, 4'b0000,1'b0,5'd0},
    '{1'b0,5'd0, 1'b1,1'b1,1'b0, 1'b0,5'd0, 1'b0,1'b0, 4'b0010,1'b0,5'd0}, // R5 manual completion
    '{1'b0,5'd0, 1'b1,1'b1,1'b1, 1'b0,5'd0, 1'b0,1'b0, 4'b0110,1'b1,5'd7}, // R6 auto release
    '{1'b0,5'd0, 1'b0,1'b0,1'b0, 1'b0,5'd0, 1'b0,1'b1, 4'b0100,1'b0,5'd0}, // R2 completion drained
    '{1'b1,5'd9, 1'b0,1'b0,1'b0, 1'b0,5'd0, 1'b0,1'b0, 4'b0000,1'b0,5'd0},
    '{1'b0,5'd0, 1'b1,1'b0,1'b1, 1'b0,5'd0, 1'b0,1'b0, 4'b0110,1'b0,5'd0}, // R5 failed with auto
    '{1'b0,5'd0, 1'b0,1'b0,1'b0, 1'b1,5'd12,1'b0,1'b0, 4'b0111,1'b0,5'd0}, // R1 rx arrives
    '{1'b0,5'd0, 1'b0,1'b0,1'b0, 1'b0,5'd0, 1'b1,1'b1, 4'b0100,1'b0,5'd0}, // R1 R2 drained
    '{1'b0,5'd0, 1'b1,1'b1,1'b1, 1'b0,5'd0, 1'b0,1'b0, 4'b0100,1'b0,5'd0}, // R9 done on empty
    '{1'b0,5'd0, 1'b0,1'b0,1'b0, 1'b0,5'd0, 1'b1,1'b1, 4'b0100,1'b0,5'd0}, // R9 pops on empty
    '{1'b1,5'd5, 1'b1,1'b1,1'b1, 1'b0,5'd0, 1'b0,1'b0, 4'b0000,1'b0,5'd0}, // R9 done before push lands
    '{1'b0,5'd0, 1'b1,1'b1,1'b1, 1'b0,5'd0, 1'b0,1'b0, 4'b0100,1'b1,5'd5}  // R6 release pkt 5
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearIn();
    hostTxEnq = 0; txDone = 0; txOk = 0; autoRelease = 0; rxArrive = 0;
    hostRxDeq = 0; hostDoneDeq = 0; ovfClr = 0;
  endtask

  task automatic stepRx(input logic [4:0] p);
    @(negedge clk); clearIn(); rxArrive = 1; rxPkt = p;
    @(posedge clk); #1;
  endtask

  initial begin
    #500000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    #1;
    chk("R10 reset status", intStatus, 4'b0100);
    chk("R10 reset release", relValid, 0);
    intEn = 4'b0000; #1; chk("R4 irq all disabled", irq, 0);
    intEn = 4'b0100; #1; chk("R4 irq tx-empty enabled", irq, 1);
    intEn = 4'b1011; #1; chk("R4 irq other bits only", irq, 0);
    intEn = 4'b1111;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      hostTxEnq = VEC[i].txEnq; hostTxPkt = VEC[i].txPkt; txDone = VEC[i].done;
      txOk = VEC[i].ok; autoRelease = VEC[i].autoR; rxArrive = VEC[i].rxArr;
      rxPkt = VEC[i].rxP; hostRxDeq = VEC[i].rxDeq; hostDoneDeq = VEC[i].doneDeq;
      ovfClr = 0;
      #1;
      chk($sformatf("R6 relValid vec %0d", i), relValid, VEC[i].expRel);
      if (VEC[i].expRel) chk($sformatf("R6 relPkt vec %0d", i), relPkt, VEC[i].expRelPkt);
      @(posedge clk); #1;
      chk($sformatf("R1 R2 R3 status vec %0d", i), intStatus, VEC[i].expStat);
      chk($sformatf("R4 irq vec %0d", i), irq, |VEC[i].expStat);
    end

    // R7 order and depth, R8 overflow on the receive queue
    for (int k = 1; k <= 8; k++) stepRx(5'(k));
    chk("R7 eight entries accepted", intStatus, 4'b0101);
    stepRx(5'd20);
    chk("R8 overflow flag set", intStatus, 4'b1101);
    chk("R8 head unchanged", rxHeadPkt, 5'd1);
    intEn = 4'b1000; #1; chk("R4 irq overflow only", irq, 1);
    @(negedge clk); clearIn(); @(posedge clk); #1;
    chk("R8 overflow sticky", intStatus[3], 1);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk); clearIn();
      chk($sformatf("R7 order entry %0d", k), rxHeadPkt, 5'(k));
      hostRxDeq = 1;
      @(posedge clk); #1;
    end
    chk("R8 dropped push not stored", intStatus, 4'b1100);
    @(negedge clk); clearIn(); ovfClr = 1;
    @(posedge clk); #1;
    chk("R8 overflow cleared", intStatus, 4'b0100);

    // R5 completion queue carries the failed packet number
    @(negedge clk); clearIn(); hostTxEnq = 1; hostTxPkt = 5'd17;
    @(posedge clk); #1;
    chk("R5 tx head", txHeadPkt, 5'd17);
    @(negedge clk); clearIn(); txDone = 1; txOk = 0; autoRelease = 1;
    #1; chk("R6 no release on fail", relValid, 0);
    @(posedge clk); #1;
    chk("R5 completion head", doneHeadPkt, 5'd17);
    chk("R5 status after fail", intStatus, 4'b0110);
    @(negedge clk); clearIn();
    @(posedge clk); #1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule